// File: doc/BRIEF.md
# Dual-Width Condition Code Generator

This block is the integer add/subtract stage of a 64-bit processor that still has to run code written for a 32-bit machine. Every operation produces one 64-bit result and two flag sets from it. The wide set describes the full 64-bit result. The narrow set describes the low 32 bits, read as if they were a 32-bit result. Because a single add or subtract fills in both sets, the instruction set does not need separate 32-bit and 64-bit arithmetic opcodes.

Both flag sets are captured in a register on a clock edge where the update enable is high. A branch-evaluation port reads the latched flags without a clock. The caller gives it a condition code and the set to test. It answers taken or not taken for zero/nonzero, negative/non-negative or overflow/no-overflow tests.

Top module: `ddcc_top`

## Requirements
- R1: `result` is combinational and equals `opa + opb` when `sub` is 0, or `opa - opb` when `sub` is 1, taken modulo 2^64.
- R2: A flag set is packed as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. In the wide set, N is result bit 63 and Z is 1 when all 64 result bits are zero.
- R3: The wide V is 1 when the true signed 64-bit sum or difference does not fit in 64 bits.
- R4: The wide C is the carry out of bit 63 for an add. For a subtract it is the borrow, which is 1 exactly when `opa < opb` as unsigned numbers.
- R5: The narrow set applies the same N, Z, V and C rules to bits 31:0 of the operands and of the result. N is bit 31 and C comes from bit 31.
- R6: One enabled operation updates both sets on the same clock edge.
- R7: While `flag_we` is 0, both latched sets keep their values.
- R8: When `rst_n` is low at a rising edge, both sets become 4'b0000.
- R9: `br_cond` selects the test: 0 = Z, 1 = not Z, 2 = N, 3 = not N, 4 = V, 5 = not V. The test is applied to the narrow set when `br_narrow` is 1 and to the wide set otherwise.
- R10: Codes 6 and 7 of `br_cond` never give a taken branch.
- R11: `br_taken` is combinational from the latched flags. It therefore shows the most recent enabled operation from the cycle after that operation's edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| sub | input | 1 | 1 selects subtract, 0 selects add |
| flag_we | input | 1 | Latch both flag sets on this edge |
| br_cond | input | 3 | Branch condition code |
| br_narrow | input | 1 | 1 tests the 32-bit set, 0 tests the 64-bit set |
| result | output | 64 | Sum or difference |
| cc_wide | output | 4 | Latched 64-bit flags {N,Z,V,C} |
| cc_narrow | output | 4 | Latched 32-bit flags {N,Z,V,C} |
| br_taken | output | 1 | Branch decision |

## Verification
The operands are chosen so that the two sets have to disagree. Examples are a low-half signed overflow with no 64-bit overflow, a carry out of bit 31 alone, and a low half of zero under a nonzero upper half. Other operands hit both widths at once: all-ones plus one, the most negative value minus one, and zero minus one. Pseudo-random operand pairs with both add and subtract are checked against a behavioural model that uses wide signed arithmetic. Cycles with the enable low show that the flags hold. After every edge the bench sweeps all eight condition codes over both sets, which separates the condition decode from the choice of set.

// File: rtl/ddcc_pkg.sv
// Shared types for the dual-width condition code generator.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package ddcc_pkg;
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_t;

    typedef enum logic [2:0] {
        BR_EQ   = 3'd0,
        BR_NE   = 3'd1,
        BR_NEG  = 3'd2,
        BR_NNEG = 3'd3,
        BR_OVF  = 3'd4,
        BR_NOVF = 3'd5
    } brcond_e;
endpackage

// File: rtl/ddcc_ccgen.sv
// Width-generic adder/subtractor with condition code generation.
// Assumes two's complement operands; for subtract C reports a borrow.
module ddcc_ccgen #(
    parameter int SW = 64
) (
    input  logic [SW-1:0]   a,
    input  logic [SW-1:0]   b,
    input  logic            sub,
    output logic [SW-1:0]   sum,
    output ddcc_pkg::ccf_t  cc
);
    localparam int XW = SW + 1;

    logic [SW-1:0] bx;
    logic [XW-1:0] ext;

    // Invert the second operand for subtract and add with carry-in.
    always_comb begin
        bx  = b ^ {SW{sub}};
        ext = {1'b0, a} + {1'b0, bx} + {{SW{1'b0}}, sub};
        sum = ext[SW-1:0];
    end

    // Derive N, Z, V, C from the sum and the operand signs.
    always_comb begin
        cc.n = sum[SW-1];
        cc.z = ~|sum;
        cc.v = (a[SW-1] == bx[SW-1]) && (sum[SW-1] != a[SW-1]);
        cc.c = ext[SW] ^ sub;
    end
endmodule

// File: rtl/ddcc_ccreg.sv
// Holding register for both flag sets; loads only when enabled.
// Assumes a synchronous active-low reset that clears all flags.
module ddcc_ccreg (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  ddcc_pkg::ccf_t  d_wide,
    input  ddcc_pkg::ccf_t  d_narrow,
    output ddcc_pkg::ccf_t  q_wide,
    output ddcc_pkg::ccf_t  q_narrow
);
    // Clear on reset, capture both sets together on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_wide   <= '0;
            q_narrow <= '0;
        end else if (we) begin
            q_wide   <= d_wide;
            q_narrow <= d_narrow;
        end
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(q_wide) && $stable(q_narrow)));

    // R6
    both_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q_wide == $past(d_wide) && q_narrow == $past(d_narrow)));
endmodule

// File: rtl/ddcc_brunit.sv
// Branch evaluator: selects one latched flag set and applies the test.
// Assumes codes outside 0..5 are reserved and must read not-taken.
module ddcc_brunit (
    input  ddcc_pkg::ccf_t  cc_wide,
    input  ddcc_pkg::ccf_t  cc_narrow,
    input  logic            use_narrow,
    input  logic [2:0]      cond,
    output logic            taken
);
    import ddcc_pkg::*;

    ccf_t sel;

    // Pick the flag set named by the branch.
    always_comb sel = use_narrow ? cc_narrow : cc_wide;

    // Decode the condition code against the chosen set.
    always_comb begin
        case (brcond_e'(cond))
            BR_EQ:   taken = sel.z;
            BR_NE:   taken = !sel.z;
            BR_NEG:  taken = sel.n;
            BR_NNEG: taken = !sel.n;
            BR_OVF:  taken = sel.v;
            BR_NOVF: taken = !sel.v;
            default: taken = 1'b0;
        endcase
    end

    // R10
    always_comb begin
        rsvd_code_chk: assert (!(cond[2] && cond[1] && taken));
    end
endmodule

// File: rtl/ddcc_top.sv
// Dual-width condition code generator: one add/subtract yields a 64-bit
// result plus flag sets for the full width and for the low half.
// Assumes HALF < W; the branch port reads registered flags only.
module ddcc_top #(
    parameter int W    = 64,
    parameter int HALF = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic            sub,
    input  logic            flag_we,
    input  logic [2:0]      br_cond,
    input  logic            br_narrow,
    output logic [W-1:0]    result,
    output logic [3:0]      cc_wide,
    output logic [3:0]      cc_narrow,
    output logic            br_taken
);
    import ddcc_pkg::*;

    ccf_t           nx_wide, nx_narrow, q_wide, q_narrow;
    logic [HALF-1:0] half_sum;

    ddcc_ccgen #(.SW(W)) u_wide (
        .a(opa), .b(opb), .sub(sub), .sum(result), .cc(nx_wide)
    );

    ddcc_ccgen #(.SW(HALF)) u_narrow (
        .a(opa[HALF-1:0]), .b(opb[HALF-1:0]), .sub(sub),
        .sum(half_sum), .cc(nx_narrow)
    );

    ddcc_ccreg u_reg (
        .clk(clk), .rst_n(rst_n), .we(flag_we),
        .d_wide(nx_wide), .d_narrow(nx_narrow),
        .q_wide(q_wide), .q_narrow(q_narrow)
    );

    ddcc_brunit u_br (
        .cc_wide(q_wide), .cc_narrow(q_narrow),
        .use_narrow(br_narrow), .cond(br_cond), .taken(br_taken)
    );

    // Present the latched sets as plain vectors.
    always_comb begin
        cc_wide   = q_wide;
        cc_narrow = q_narrow;
    end

    // R5
    always_comb begin
        half_sum_chk: assert (half_sum == result[HALF-1:0]);
    end

    // R2
    wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (cc_wide[2] == ($past(result) == '0)));

    // R5
    narrow_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (cc_narrow[3] == $past(result[HALF-1])));

    // R6
    zero_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_wide[2] |-> cc_narrow[2]);

    // R11
    br_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_cond == 3'd0) |-> (br_taken == (br_narrow ? cc_narrow[2] : cc_wide[2])));
endmodule

// File: tb/test_ddcc_top.sv
`timescale 1ns/100ps
module test_ddcc_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] opa = 0, opb = 0;
    logic        sub = 0, flag_we = 0;
    logic [2:0]  br_cond = 0;
    logic        br_narrow = 0;
    logic [63:0] result;
    logic [3:0]  cc_wide, cc_narrow;
    logic        br_taken;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_wide = 0, m_narrow = 0;

    always #2 clk = ~clk;

    ddcc_top i_ddcc_top (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .sub(sub),
        .flag_we(flag_we), .br_cond(br_cond), .br_narrow(br_narrow),
        .result(result), .cc_wide(cc_wide), .cc_narrow(cc_narrow),
        .br_taken(br_taken)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural flag model on n-bit values using wide signed integers.
    function automatic logic [3:0] model_flags(input logic [63:0] a, input logic [63:0] b,
                                               input bit s, input int n);
        logic [127:0] ua, ub, ur, mask;
        logic signed [127:0] sa, sb, sr, lo, hi;
        logic nf, zf, vf, cf;
        mask = (128'd1 << n) - 1;
        ua = {64'd0, a} & mask;
        ub = {64'd0, b} & mask;
        sa = (ua[n-1]) ? $signed(ua - (128'd1 << n)) : $signed(ua);
        sb = (ub[n-1]) ? $signed(ub - (128'd1 << n)) : $signed(ub);
        sr = s ? sa - sb : sa + sb;
        lo = -($signed(128'd1) <<< (n-1));
        hi = ($signed(128'd1) <<< (n-1)) - 1;
        vf = (sr < lo) || (sr > hi);
        ur = s ? (ua - ub) & mask : (ua + ub);
        cf = s ? (ua < ub) : ur[n];
        ur = ur & mask;
        nf = ur[n-1];
        zf = (ur == 0);
        return {nf, zf, vf, cf};
    endfunction

    function automatic bit model_br(input logic [3:0] f, input int c);
        case (c)
            0: return f[2];
            1: return !f[2];
            2: return f[3];
            3: return !f[3];
            4: return f[1];
            5: return !f[1];
            default: return 1'b0;
        endcase
    endfunction

    // Sweep every condition over both sets against the model flags.
    task automatic sweep_branches();
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                br_narrow = s[0];
                br_cond = c[2:0];
                #0.1;
                chk(br_taken == model_br(s ? m_narrow : m_wide, c),
                    (c >= 6) ? "R10" : "R9/R11", {63'd0, br_taken},
                    {63'd0, model_br(s ? m_narrow : m_wide, c)});
            end
        end
    endtask

    // One clocked operation: drive after negedge, check result, clock, check flags.
    task automatic step(input logic [63:0] a, input logic [63:0] b, input bit s, input bit we);
        logic [63:0] er;
        @(negedge clk);
        opa = a; opb = b; sub = s; flag_we = we;
        #0.5;
        er = s ? a - b : a + b;
        chk(result == er, "R1", result, er);
        if (we) begin
            m_wide   = model_flags(a, b, s, 64);
            m_narrow = model_flags(a, b, s, 32);
        end
        @(posedge clk);
        #0.5;
        chk(cc_wide == m_wide, we ? "R2/R3/R4/R6" : "R7", {60'd0, cc_wide}, {60'd0, m_wide});
        chk(cc_narrow == m_narrow, we ? "R5/R6" : "R7", {60'd0, cc_narrow}, {60'd0, m_narrow});
        sweep_branches();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] lf;
        repeat (3) @(posedge clk);
        #0.5;
        // R8: reset clears both sets
        chk(cc_wide == 4'b0, "R8", {60'd0, cc_wide}, 64'd0);
        chk(cc_narrow == 4'b0, "R8", {60'd0, cc_narrow}, 64'd0);
        sweep_branches();
        @(negedge clk);
        rst_n = 1;

        step(64'd0, 64'd0, 0, 1);
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);   // R4 carry, both zero
        step(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);   // R3 wide overflow
        step(64'h0000_0000_7FFF_FFFF, 64'd1, 0, 1);   // R5 narrow-only overflow
        step(64'h0000_0001_FFFF_FFFF, 64'd1, 0, 1);   // R5 narrow carry/zero only
        step(64'h8000_0000_0000_0000, 64'd1, 1, 1);   // R3 subtract overflow
        step(64'd0, 64'd1, 1, 1);                      // R4 borrow both
        step(64'd5, 64'd5, 1, 1);                      // zero after subtract
        step(64'h0000_0000_8000_0000, 64'd1, 1, 1);   // R5 narrow sub overflow
        step(64'd1, 64'd2, 0, 0);                      // R7 hold
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0);   // R7 hold
        step(64'd3, 64'd1, 0, 1);                      // R11 new flags

        lf = 64'h1234_5678_9ABC_DEF1;
        for (int i = 0; i < 200; i++) begin
            logic [63:0] ra, rb;
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            ra = lf;
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            rb = {lf[31:0], lf[63:32]};
            if (i % 7 == 0) rb = {rb[63:32], ra[31:0]};
            step(ra, rb, lf[3], (i % 5) != 4);
        end

        // R8: reset mid-run clears flags again
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #0.5;
        m_wide = 0; m_narrow = 0;
        chk(cc_wide == 4'b0 && cc_narrow == 4'b0, "R8", {56'd0, cc_wide, cc_narrow}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule